// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address and a pair of read/write permission bits, or into an 8-bit fault status. The address comes with an access kind (read, write or instruction fetch) and a user/privileged flag. The walk reads up to two descriptors from memory through a single-outstanding read request/response port. The first-level descriptor can map a 1 MB section directly or point at a coarse or fine second-level table. A second-level entry maps a 64 KB, 4 KB or 1 KB page.

Addresses in the lowest 32 MB are moved up by a process-ID offset before any other step. A clear enable bit in the control input bypasses translation. The translation inputs are live ports: table base, domain access word, process offset and control word. They must stay stable while a walk is in progress. One request is taken at a time. The result is held on the outputs and announced by a one-cycle done strobe.

Top module: `ttw_walker`

## Requirements
- R1: A request address below 0x02000000 has `cfg_pid` added to it, modulo 2^32. The sum is used for every later step, including the table addresses and the bypass result.
- R2: With `cfg_ctrl[0]` = 0 the walk issues no memory read. It reports `pa` equal to the relocated address, with `perm_rd` = `perm_wr` = 1 and no fault.
- R3: With `cfg_ctrl[0]` = 1 the first read goes to {`cfg_tbase[31:14]`, va[31:20], 2'b00}. `mem_req` is a one-cycle pulse, and no second request is issued before the response arrives.
- R4: The type field is bits [1:0] of the first descriptor. The domain number is bits [8:5]. The 2-bit access value is `cfg_dom[2*domain+1 : 2*domain]`. A first-level type of 0 faults with code 5.
- R5: An access value of 0 or 2 faults before any permission check. The code is 9 when the first-level type is 2 (section) and 11 when it is 1 or 3 (table).
- R6: A section (type 2) gives `pa` = {desc[31:20], va[19:0]}, with its permission field at desc[11:10]. No second read is made.
- R7: A coarse table (type 1) is read at {desc[31:10], va[19:12], 2'b00}. A fine table (type 3) is read at {desc[31:12], va[19:10], 2'b00}.
- R8: A second-level type of 0 faults with code 7. A 1 KB entry (type 3) found in a coarse table also faults with code 7.
- R9: Second-level type 1 is a 64 KB page: `pa` = {desc[31:16], va[15:0]}. Type 2 is a 4 KB page: {desc[31:12], va[11:0]}. For both, the permission field is desc bits [5:4], [7:6], [9:8] or [11:10], selected by va[15:14] (64 KB) or va[11:10] (4 KB) equal to 0, 1, 2 or 3. A 1 KB page gives {desc[31:10], va[9:0]} with its field at desc[5:4].
- R10: Access value 3 grants read and write whatever the permission field says.
- R11: For access value 1 the permission field decides. Writes are `req_kind` = 2'b01; kinds 2'b00 (read), 2'b10 (fetch) and 2'b11 count as reads. Field 3 allows everything. Field 2 gives privileged read/write and user read only. Field 1 gives privileged read/write and nothing to user. Field 0 denies writes; reads are then allowed for privileged only when `cfg_ctrl[9:8]` = 1, for everyone when it is 2, and for nobody otherwise.
- R12: A denied access faults with code 13 (section) or 15 (page). On every fault, `fault_status` = {2'b00, access value, code}, and `pa`, `perm_rd` and `perm_wr` read 0.
- R13: `req_ready` is high only when idle. A request is taken when `req_valid` and `req_ready` are both high; `req_valid` while busy is ignored. `done` pulses for one cycle per accepted request, and outputs hold until the next result. After reset: `req_ready` = 1, and `done`, `mem_req`, `fault` and `pa` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 = user, 0 = privileged |
| cfg_ctrl | input | 32 | Bit 0 translation enable, bits 9:8 read-only mode |
| cfg_tbase | input | 32 | First-level table base |
| cfg_dom | input | 32 | Sixteen 2-bit domain access values |
| cfg_pid | input | 32 | Offset added to low addresses |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | 32 | Descriptor data |
| done | output | 1 | One-cycle completion strobe |
| pa | output | 32 | Physical address |
| perm_rd | output | 1 | Read allowed |
| perm_wr | output | 1 | Write allowed |
| fault | output | 1 | Walk faulted |
| fault_status | output | 8 | {2'b00, access value, code} |

## Verification
The bench builds the walker with its default relocation limit of 0x02000000. About a third of its random addresses are drawn below that limit, so both the relocated and the untouched paths are reached. A random process offset can push a relocated address across a table boundary. The response latency is varied from zero to three wait cycles, which exercises the wait states of both levels. Random control, domain and descriptor words reach every combination of descriptor type, access value and permission field.

// File: rtl/ttw_pkg.sv
// Package: shared widths, walk states and fault codes for the table walker.
// Assumes 32-bit virtual/physical addresses and 32-bit descriptors.
package ttw_pkg;

    localparam int TTW_AW  = 32;
    localparam int TTW_FSW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    localparam logic [1:0] KIND_WRITE = 2'b01;

    localparam logic [3:0] FC_L1_XLATE   = 4'd5;
    localparam logic [3:0] FC_L2_XLATE   = 4'd7;
    localparam logic [3:0] FC_SEC_DOMAIN = 4'd9;
    localparam logic [3:0] FC_TBL_DOMAIN = 4'd11;
    localparam logic [3:0] FC_SEC_PERM   = 4'd13;
    localparam logic [3:0] FC_PAGE_PERM  = 4'd15;

    // Pack the access value and code into the status byte.
    function automatic logic [TTW_FSW-1:0] pack_status(input logic [1:0] acc,
                                                       input logic [3:0] code);
        return {2'b00, acc, code};
    endfunction

endpackage

// File: rtl/ttw_l1_decode.sv
// First-level descriptor decode: type, domain access value, section mapping
// and second-level table address. Purely combinational.
// Assumes desc is the first-level entry fetched for va.
module ttw_l1_decode
    import ttw_pkg::*;
(
    input  logic [TTW_AW-1:0] va,
    input  logic [31:0]       desc,
    input  logic [31:0]       dom_word,
    output logic [1:0]        l1_type,
    output logic [1:0]        acc,
    output logic [TTW_AW-1:0] sec_pa,
    output logic [1:0]        sec_ap,
    output logic [TTW_AW-1:0] l2_addr
);

    logic [4:0] dom_shift;

    // Extract type, access value and section fields.
    always_comb begin
        l1_type   = desc[1:0];
        dom_shift = {desc[8:5], 1'b0};
        acc       = dom_word[dom_shift +: 2];
        sec_pa    = {desc[31:20], va[19:0]};
        sec_ap    = desc[11:10];
    end

    // Second-level address: coarse for type 1, fine otherwise.
    always_comb begin
        if (desc[1:0] == 2'd1)
            l2_addr = {desc[31:10], va[19:12], 2'b00};
        else
            l2_addr = {desc[31:12], va[19:10], 2'b00};
    end

endmodule

// File: rtl/ttw_l2_decode.sv
// Second-level descriptor decode: page size, physical address, subpage
// permission field and translation fault. Purely combinational.
// Assumes coarse is set when the parent first-level entry was type 1.
module ttw_l2_decode
    import ttw_pkg::*;
(
    input  logic [TTW_AW-1:0] va,
    input  logic [31:0]       desc,
    input  logic              coarse,
    output logic              xlate_bad,
    output logic [TTW_AW-1:0] pg_pa,
    output logic [1:0]        pg_ap
);

    // Pick one of four 2-bit subpage fields starting at bit 4.
    function automatic logic [1:0] sub_ap(input logic [31:0] d, input logic [1:0] s);
        case (s)
            2'd0:    return d[5:4];
            2'd1:    return d[7:6];
            2'd2:    return d[9:8];
            default: return d[11:10];
        endcase
    endfunction

    // Decode the page type into address and permission field.
    always_comb begin
        xlate_bad = 1'b0;
        pg_pa     = '0;
        pg_ap     = 2'd0;
        case (desc[1:0])
            2'd0: xlate_bad = 1'b1;
            2'd1: begin
                pg_pa = {desc[31:16], va[15:0]};
                pg_ap = sub_ap(desc, va[15:14]);
            end
            2'd2: begin
                pg_pa = {desc[31:12], va[11:0]};
                pg_ap = sub_ap(desc, va[11:10]);
            end
            default: begin
                if (coarse) begin
                    xlate_bad = 1'b1;
                end else begin
                    pg_pa = {desc[31:10], va[9:0]};
                    pg_ap = desc[5:4];
                end
            end
        endcase
    end

endmodule

// File: rtl/ttw_perm.sv
// Access permission evaluation from permission field, domain access value,
// privilege and access direction. Purely combinational.
// Assumes ro_mode carries control bits [9:8].
module ttw_perm (
    input  logic [1:0] ap,
    input  logic [1:0] acc,
    input  logic       user,
    input  logic       is_write,
    input  logic [1:0] ro_mode,
    output logic       can_rd,
    output logic       can_wr
);

    // Evaluate read/write rights; both low means the access is denied.
    always_comb begin
        can_rd = 1'b0;
        can_wr = 1'b0;
        if (acc == 2'd3) begin
            can_rd = 1'b1;
            can_wr = 1'b1;
        end else begin
            case (ap)
                2'd0: begin
                    if (!is_write) begin
                        case (ro_mode)
                            2'd1:    can_rd = !user;
                            2'd2:    can_rd = 1'b1;
                            default: can_rd = 1'b0;
                        endcase
                    end
                end
                2'd1: begin
                    can_rd = !user;
                    can_wr = !user;
                end
                2'd2: begin
                    can_rd = user ? !is_write : 1'b1;
                    can_wr = !user;
                end
                default: begin
                    can_rd = 1'b1;
                    can_wr = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/ttw_walker.sv
// Two-level translation table walker. Takes one request at a time, relocates
// low addresses, optionally bypasses translation, reads up to two descriptors
// and reports a physical address with permissions or a fault status.
// Assumes the cfg_* inputs stay stable from acceptance until done, and that
// memory answers each request with exactly one mem_rvalid pulse.
module ttw_walker
    import ttw_pkg::*;
#(
    parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TTW_AW-1:0] req_va,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic [31:0]       cfg_ctrl,
    input  logic [31:0]       cfg_tbase,
    input  logic [31:0]       cfg_dom,
    input  logic [31:0]       cfg_pid,
    output logic              mem_req,
    output logic [TTW_AW-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [TTW_AW-1:0] pa,
    output logic              perm_rd,
    output logic              perm_wr,
    output logic              fault,
    output logic [TTW_FSW-1:0] fault_status
);

    walk_state_e        st;
    logic [TTW_AW-1:0]  va_q;
    logic               write_q;
    logic               user_q;
    logic [31:0]        desc1_q;

    logic [TTW_AW-1:0]  pa_q;
    logic               rd_q;
    logic               wr_q;
    logic               fault_q;
    logic [TTW_FSW-1:0] fs_q;

    logic [TTW_AW-1:0]  va_reloc;
    logic [TTW_AW-1:0]  l1_addr;
    logic [31:0]        l1_desc;
    logic [1:0]         l1_type;
    logic [1:0]         acc;
    logic [TTW_AW-1:0]  sec_pa;
    logic [1:0]         sec_ap;
    logic [TTW_AW-1:0]  l2_addr;
    logic               pg_bad;
    logic [TTW_AW-1:0]  pg_pa;
    logic [1:0]         pg_ap;
    logic [1:0]         ap_sel;
    logic               can_rd;
    logic               can_wr;

    logic               res_fault;
    logic [3:0]         res_code;
    logic [TTW_AW-1:0]  res_pa;
    logic               go_l2;

    // Relocate low addresses by the process offset.
    always_comb begin
        va_reloc = (req_va < RELOC_LIMIT) ? (req_va + cfg_pid) : req_va;
    end

    // First-level address and descriptor source: live response or stored copy.
    always_comb begin
        l1_addr = {cfg_tbase[31:14], va_q[31:20], 2'b00};
        l1_desc = (st == ST_L1_WAIT) ? mem_rdata : desc1_q;
    end

    ttw_l1_decode u_l1 (
        .va       (va_q),
        .desc     (l1_desc),
        .dom_word (cfg_dom),
        .l1_type  (l1_type),
        .acc      (acc),
        .sec_pa   (sec_pa),
        .sec_ap   (sec_ap),
        .l2_addr  (l2_addr)
    );

    ttw_l2_decode u_l2 (
        .va        (va_q),
        .desc      (mem_rdata),
        .coarse    (desc1_q[1:0] == 2'd1),
        .xlate_bad (pg_bad),
        .pg_pa     (pg_pa),
        .pg_ap     (pg_ap)
    );

    // Permission field comes from the section or from the page by walk level.
    always_comb begin
        ap_sel = (st == ST_L2_WAIT) ? pg_ap : sec_ap;
    end

    ttw_perm u_perm (
        .ap       (ap_sel),
        .acc      (acc),
        .user     (user_q),
        .is_write (write_q),
        .ro_mode  (cfg_ctrl[9:8]),
        .can_rd   (can_rd),
        .can_wr   (can_wr)
    );

    // Decide the outcome of the level whose descriptor is arriving.
    always_comb begin
        res_fault = 1'b0;
        res_code  = 4'd0;
        res_pa    = '0;
        go_l2     = 1'b0;
        if (st == ST_L2_WAIT) begin
            if (pg_bad) begin
                res_fault = 1'b1;
                res_code  = FC_L2_XLATE;
            end else if (!(can_rd || can_wr)) begin
                res_fault = 1'b1;
                res_code  = FC_PAGE_PERM;
            end else begin
                res_pa = pg_pa;
            end
        end else begin
            if (l1_type == 2'd0) begin
                res_fault = 1'b1;
                res_code  = FC_L1_XLATE;
            end else if (acc == 2'd0 || acc == 2'd2) begin
                res_fault = 1'b1;
                res_code  = (l1_type == 2'd2) ? FC_SEC_DOMAIN : FC_TBL_DOMAIN;
            end else if (l1_type == 2'd2) begin
                if (!(can_rd || can_wr)) begin
                    res_fault = 1'b1;
                    res_code  = FC_SEC_PERM;
                end else begin
                    res_pa = sec_pa;
                end
            end else begin
                go_l2 = 1'b1;
            end
        end
    end

    // Walk sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            va_q    <= '0;
            write_q <= 1'b0;
            user_q  <= 1'b0;
            desc1_q <= '0;
            pa_q    <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            fault_q <= 1'b0;
            fs_q    <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= va_reloc;
                        write_q <= (req_kind == KIND_WRITE);
                        user_q  <= req_user;
                        if (cfg_ctrl[0]) begin
                            st <= ST_L1_REQ;
                        end else begin
                            pa_q    <= va_reloc;
                            rd_q    <= 1'b1;
                            wr_q    <= 1'b1;
                            fault_q <= 1'b0;
                            fs_q    <= '0;
                            st      <= ST_DONE;
                        end
                    end
                end
                ST_L1_REQ: st <= ST_L1_WAIT;
                ST_L1_WAIT: begin
                    if (mem_rvalid) begin
                        desc1_q <= mem_rdata;
                        if (go_l2) begin
                            st <= ST_L2_REQ;
                        end else begin
                            pa_q    <= res_pa;
                            rd_q    <= !res_fault && can_rd;
                            wr_q    <= !res_fault && can_wr;
                            fault_q <= res_fault;
                            fs_q    <= res_fault ? pack_status(acc, res_code) : '0;
                            st      <= ST_DONE;
                        end
                    end
                end
                ST_L2_REQ: st <= ST_L2_WAIT;
                ST_L2_WAIT: begin
                    if (mem_rvalid) begin
                        pa_q    <= res_pa;
                        rd_q    <= !res_fault && can_rd;
                        wr_q    <= !res_fault && can_wr;
                        fault_q <= res_fault;
                        fs_q    <= res_fault ? pack_status(acc, res_code) : '0;
                        st      <= ST_DONE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port drive from state and result registers.
    always_comb begin
        req_ready    = (st == ST_IDLE);
        mem_req      = (st == ST_L1_REQ) || (st == ST_L2_REQ);
        mem_addr     = (st == ST_L2_REQ) ? l2_addr : l1_addr;
        done         = (st == ST_DONE);
        pa           = pa_q;
        perm_rd      = rd_q;
        perm_wr      = wr_q;
        fault        = fault_q;
        fault_status = fs_q;
    end

endmodule

// File: rtl/ttw_walker_chk.sv
// Checker for the table walker: port-level handshake and result properties.
// Assumes it is bound to every ttw_walker instance.
module ttw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req,
    input logic        done,
    input logic [31:0] pa,
    input logic        perm_rd,
    input logic        perm_wr,
    input logic        fault,
    input logic [7:0]  fault_status
);

    AST_MEM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R13

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready); // R13

    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!perm_rd && !perm_wr && pa == 32'd0)); // R12

    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_status[7:6] == 2'b00 && fault_status[0] &&
                             fault_status[3:0] >= 4'd5)); // R4

    AST_MANAGER_NO_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && fault_status[5:4] == 2'd3) |->
        (fault_status[3:0] == 4'd5 || fault_status[3:0] == 4'd7)); // R10

    AST_DOMAIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && (fault_status[3:0] == 4'd9 || fault_status[3:0] == 4'd11)) |->
        (fault_status[4] == 1'b0)); // R5

    AST_SUCCESS_HAS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> perm_rd); // R11

endmodule

bind ttw_walker ttw_walker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_req      (mem_req),
    .done         (done),
    .pa           (pa),
    .perm_rd      (perm_rd),
    .perm_wr      (perm_wr),
    .fault        (fault),
    .fault_status (fault_status)
);

// File: tb/sim_ttw_walker.sv
// Bench for ttw_walker: directed corner cases plus seeded random walks,
// compared against a reference model written from the requirements.
module sim_ttw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [31:0] c_ctrl = '0;
    logic [31:0] c_base = '0;
    logic [31:0] c_dom = '0;
    logic [31:0] c_pid = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] pa;
    logic        perm_rd;
    logic        perm_wr;
    logic        fault;
    logic [7:0]  fault_status;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m1a = '0, m1d = '0, m2a = '0, m2d = '0;
    logic [31:0] seen [0:3];
    int          nseen = 0;

    always #5 clk = ~clk;

    ttw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_kind(req_kind), .req_user(req_user),
        .cfg_ctrl(c_ctrl), .cfg_tbase(c_base), .cfg_dom(c_dom), .cfg_pid(c_pid),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .pa(pa), .perm_rd(perm_rd),
        .perm_wr(perm_wr), .fault(fault), .fault_status(fault_status)
    );

    function automatic logic [31:0] memrd(input logic [31:0] a);
        if (a == m1a) return m1d;
        if (a == m2a) return m2d;
        return 32'd0;
    endfunction

    // Reference rights: {rd, wr}
    function automatic logic [1:0] ref_prot(input logic [1:0] ap, input logic [1:0] acc,
                                            input logic user, input logic wr);
        if (acc == 2'd3) return 2'b11;
        case (ap)
            2'd0: begin
                if (wr) return 2'b00;
                if (c_ctrl[9:8] == 2'd1) return user ? 2'b00 : 2'b10;
                if (c_ctrl[9:8] == 2'd2) return 2'b10;
                return 2'b00;
            end
            2'd1: return user ? 2'b00 : 2'b11;
            2'd2: return user ? (wr ? 2'b00 : 2'b10) : 2'b11;
            default: return 2'b11;
        endcase
    endfunction

    task automatic ref_walk(input logic [31:0] va_in, input logic [1:0] kind, input logic user,
                            output logic [42:0] res, output int nrd,
                            output logic [31:0] a1, output logic [31:0] a2, output string tag);
        logic [31:0] va, d1, d2, xpa;
        logic [1:0]  t1, acc, ap, p;
        logic [3:0]  code;
        int          sh;
        va  = (va_in < 32'h0200_0000) ? va_in + c_pid : va_in;
        nrd = 0; a1 = '0; a2 = '0;
        if (!c_ctrl[0]) begin
            res = {va, 1'b1, 1'b1, 1'b0, 8'h00}; tag = "R2"; return;
        end
        a1  = {c_base[31:14], 14'd0} | ((va >> 18) & 32'h3FFC);
        d1  = memrd(a1); nrd = 1;
        t1  = d1[1:0];
        sh  = int'((d1 >> 4) & 32'h1E);
        acc = 2'((c_dom >> sh) & 32'd3);
        if (t1 == 2'd0) begin
            res = {32'd0, 3'b001, 2'b00, acc, 4'd5}; tag = "R4"; return;
        end
        if (acc == 2'd0 || acc == 2'd2) begin
            res = {32'd0, 3'b001, 2'b00, acc, (t1 == 2'd2) ? 4'd9 : 4'd11}; tag = "R5"; return;
        end
        if (t1 == 2'd2) begin
            xpa = {d1[31:20], va[19:0]}; ap = d1[11:10]; code = 4'd13; tag = "R6";
        end else begin
            a2 = (t1 == 2'd1) ? ((d1 & 32'hFFFFFC00) | ((va >> 10) & 32'h3FC))
                              : ((d1 & 32'hFFFFF000) | ((va >> 8) & 32'hFFC));
            d2 = memrd(a2); nrd = 2; code = 4'd15; tag = "R9";
            if (d2[1:0] == 2'd0 || (d2[1:0] == 2'd3 && t1 == 2'd1)) begin
                res = {32'd0, 3'b001, 2'b00, acc, 4'd7}; tag = "R8"; return;
            end
            if (d2[1:0] == 2'd1) begin
                xpa = {d2[31:16], va[15:0]};
                ap  = 2'((d2 >> (4 + 2 * int'(va[15:14]))) & 32'd3);
            end else if (d2[1:0] == 2'd2) begin
                xpa = {d2[31:12], va[11:0]};
                ap  = 2'((d2 >> (4 + 2 * int'(va[11:10]))) & 32'd3);
            end else begin
                xpa = {d2[31:10], va[9:0]}; ap = d2[5:4];
            end
        end
        p = ref_prot(ap, acc, user, kind == 2'b01);
        if (p == 2'b00) begin
            res = {32'd0, 3'b001, 2'b00, acc, code}; tag = "R12";
        end else begin
            res = {xpa, p, 1'b0, 8'h00};
            if (acc == 2'd3) tag = "R10";
            else if (tag != "R9") tag = "R11";
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Memory responder: zero to three wait cycles per request.
    initial begin
        logic [31:0] a;
        int lat;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                a = mem_addr;
                if (nseen < 4) seen[nseen] = a;
                nseen++;
                lat = int'($urandom_range(0, 3));
                repeat (lat + 1) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = memrd(a);
            end
        end
    end

    // One walk: issue, wait for done, compare result and descriptor reads.
    task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic user,
                        input string force_tag);
        logic [42:0] exp, act;
        logic [31:0] a1, a2, s0, s1;
        int          nrd, t;
        string       tag;
        ref_walk(va, kind, user, exp, nrd, a1, a2, tag);
        if (force_tag != "") tag = force_tag;
        while (!req_ready) @(negedge clk);
        nseen = 0;
        req_valid = 1'b1; req_va = va; req_kind = kind; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!done && t < 300) begin @(negedge clk); t++; end
        if (!done) begin
            check(1'b0, tag, "no done", 0, 1);
        end else begin
            act = {pa, perm_rd, perm_wr, fault, fault_status};
            check(act == exp, tag, "result", 128'(act), 128'(exp));
            s0 = (nseen > 0) ? seen[0] : 32'd0;
            s1 = (nseen > 1) ? seen[1] : 32'd0;
            check(nseen == nrd && s0 == a1 && s1 == a2, (nrd == 2) ? "R7" : "R3", "reads",
                  {32'(nseen), s0, s1}, {32'(nrd), a1, a2});
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int dn;
        logic [31:0] pa_seen;
        logic [42:0] e;
        int nr;
        logic [31:0] x1, x2;
        string tg;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(req_ready && !done && !mem_req && !fault && pa == 0, "R13", "reset state",
              {req_ready, done, mem_req, fault, pa}, {1'b1, 35'd0});

        // R2 / R1 bypass with relocation, hard-coded result
        c_ctrl = 32'h0; c_pid = 32'h0300_0000;
        walk(32'h0100_0000, 2'b01, 1'b1, "R1");
        check(pa == 32'h0400_0000 && perm_rd && perm_wr && !fault, "R1", "relocated bypass",
              {pa, perm_rd, perm_wr}, {32'h0400_0000, 2'b11});
        walk(32'h8000_0010, 2'b00, 1'b0, "R2");

        // R6 section, hand-computed
        c_ctrl = 32'h1; c_base = 32'h0000_4000; c_dom = 32'h4; c_pid = 32'h0;
        m1a = 32'h0000_448C; m1d = 32'hABC0_0C22; m2a = 32'hFFFF_FFFF; m2d = 0;
        walk(32'h1234_5678, 2'b01, 1'b1, "R6");
        check(pa == 32'hABC4_5678 && perm_wr, "R6", "section pa", pa, 32'hABC4_5678);

        // R1 relocation seen in table address with translation on
        c_pid = 32'h7E00_0000; c_dom = 32'hFFFF_FFFF;
        m1a = 32'h0000_4000 | (((32'h0012_3456 + c_pid) >> 18) & 32'h3FFC);
        m1d = 32'h5550_0002;
        walk(32'h0012_3456, 2'b00, 1'b1, "R1");
        c_pid = 0;

        // R9 64K subpage 3, 4K subpage 2, R8 1K in coarse, 1K in fine
        c_dom = 32'h1;
        m1a = 32'h0000_4000 | ((32'h0004_C000 >> 18) & 32'h3FFC);
        m1d = 32'h0010_0001;
        m2a = (m1d & 32'hFFFFFC00) | ((32'h0004_C000 >> 10) & 32'h3FC);
        m2d = 32'h1234_0000 | 32'h0000_0C01 | 32'h0000_0000;
        walk(32'h0004_C000, 2'b01, 1'b1, "R9");
        m2d = 32'h2345_6000 | 32'h0000_0202;
        walk(32'h0004_C800, 2'b00, 1'b1, "R9");
        m2d = 32'h0000_0033;
        walk(32'h0004_C000, 2'b00, 1'b0, "R8");
        m1d = 32'h0010_0003;
        m2a = (m1d & 32'hFFFFF000) | ((32'h0004_C000 >> 8) & 32'hFFC);
        m2d = 32'h7777_7433;
        walk(32'h0004_C000, 2'b01, 1'b0, "R9");
        m2d = 32'h0;
        walk(32'h0004_C000, 2'b00, 1'b0, "R8");

        // R10 manager domain over denying field; R11 AP0 modes; R12 deny
        m1d = 32'hA000_0002; m2a = 32'hFFFF_FFFF;
        c_dom = 32'h3;
        walk(32'h0004_C000, 2'b01, 1'b1, "R10");
        c_dom = 32'h1;
        for (int rs = 0; rs < 4; rs++) begin
            c_ctrl = 32'h1 | (32'(rs) << 8);
            walk(32'h0004_C000, 2'b00, 1'b0, "R11");
            walk(32'h0004_C000, 2'b10, 1'b1, "R11");
            walk(32'h0004_C000, 2'b01, 1'b0, "R12");
        end
        c_dom = 32'h2;
        walk(32'h0004_C000, 2'b00, 1'b0, "R5");

        // R13 requests while busy are ignored
        c_ctrl = 32'h1; c_dom = 32'h1;
        m1d = 32'h0010_0001;
        m2a = (m1d & 32'hFFFFFC00) | ((32'h0004_C000 >> 10) & 32'h3FC);
        m2d = 32'h4444_0FF1;
        ref_walk(32'h0004_C000, 2'b00, 1'b0, e, nr, x1, x2, tg);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = 32'h0004_C000; req_kind = 2'b00; req_user = 1'b0;
        @(negedge clk);
        req_va = 32'h9000_0000;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        dn = 0; pa_seen = '0;
        for (int i = 0; i < 40; i++) begin
            if (done) begin dn++; pa_seen = pa; end
            @(negedge clk);
        end
        check(dn == 1 && pa_seen == e[42:11], "R13", "busy request ignored",
              {32'(dn), pa_seen}, {32'd1, e[42:11]});

        // Random walks
        for (int k = 0; k < 400; k++) begin
            logic [31:0] va;
            logic [31:0] d1t;
            va     = ($urandom_range(0, 2) == 0) ? ($urandom() & 32'h01FF_FFFF) : $urandom();
            c_ctrl = {22'd0, 2'($urandom()), 7'd0, ($urandom_range(0, 7) != 0)};
            c_base = $urandom(); c_dom = $urandom(); c_pid = $urandom();
            m1a    = {c_base[31:14], 14'd0} |
                     ((((va < 32'h0200_0000) ? va + c_pid : va) >> 18) & 32'h3FFC);
            m1d    = $urandom();
            d1t    = m1d;
            m2a    = (d1t[1:0] == 2'd1)
                     ? ((d1t & 32'hFFFFFC00) | ((((va < 32'h0200_0000) ? va + c_pid : va) >> 10) & 32'h3FC))
                     : ((d1t & 32'hFFFFF000) | ((((va < 32'h0200_0000) ? va + c_pid : va) >> 8) & 32'hFFC));
            m2d    = $urandom();
            walk(va, 2'($urandom()), 1'($urandom()), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule